// File: doc/BRIEF.md
# Horizontal Lock and Transmitter Presence Detector

This block is a digital stand-in for the integrating capacitor detector that a television sync processor uses to decide two things: whether the horizontal oscillator loop is locked to incoming video, and whether any transmitter is present at all. A clamped unsigned accumulator represents the charge on the detector capacitor. It rises while the separated horizontal sync strobe is high. How it falls depends on the video source. With internal video it falls only inside the phase-detector gate window where sync is absent. With external video or in text mode it leaks at a small constant rate.

Two hysteretic comparators watch the accumulator. The upper one selects the long (slow) phase-detector time constant once the level is high. This selection is only honoured with internal video; other sources force the short (fast) constant. The lower one tracks transmitter presence and drives a mute flag. With internal video, presence doubles as the coincidence (in-lock) indication. All analog switching levels are expressed as integer ratios of full scale, and the accumulator value itself is available on a port.

Top module: `hlock_detector`

## Requirements
- R1: During and after reset, `level_o` is 0, `mute_o` is 1, `pd_slow_o` is 0 (fast), and `in_sync_o` is 0.
- R2: Internal source (`ext_sel_i`=0, `text_sel_i`=0): each cycle with `hsync_i`=1 adds CHARGE_STEP (default 125) to the level, whatever `gate_i` is.
- R3: Internal source: a cycle with `gate_i`=1 and `hsync_i`=0 subtracts GATE_STEP (default 125). A cycle with both low leaves the level unchanged.
- R4: External source (`ext_sel_i`=1) or text mode (`text_sel_i`=1, which takes precedence): the level changes by CHARGE_STEP−LEAK_STEP (default +121) per cycle with sync and by −LEAK_STEP (default −4) per cycle without sync. `gate_i` has no effect.
- R5: The level saturates at 0 and at 2^ACC_W−1 (default 65535) and never wraps.
- R6: The slow-select comparator turns on when the level is at least full×67/98 (44804). It turns off when the level is below full×61/98 (40792). Between those two values it keeps its state.
- R7: `pd_slow_o` (1 = slow time constant) follows the slow-select comparator only for the internal source. It is 0 for the external source and in text mode, while the comparator keeps its state.
- R8: The presence comparator turns on when the level is at least full×28/98 (18724). It turns off when the level is below full×8/98 (5349). `mute_o` is the inverse of this comparator.
- R9: `in_sync_o` is 1 only when the source is internal and a transmitter is present (`mute_o`=0).
- R10: Each flag changes on the same clock edge as the level that caused the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Separated horizontal sync strobe |
| gate_i | input | 1 | Phase-detector gate window |
| ext_sel_i | input | 1 | 1 selects the external video source |
| text_sel_i | input | 1 | 1 selects text mode |
| level_o | output | ACC_W | Accumulator level |
| in_sync_o | output | 1 | Coincidence (horizontal lock) flag |
| pd_slow_o | output | 1 | 1 selects the slow phase-detector time constant |
| mute_o | output | 1 | 1 means no transmitter detected |

## Verification
The assertions assume the synchronous inputs change only between clock edges. They also assume the default step sizes are much smaller than the hysteresis bands, so a single step can never cross both thresholds of one comparator. The stimulus drives inputs on the falling edge and keeps every step at its default. Each comparator is approached from both sides, and held in its band, over runs long enough to reach each threshold and each clamp. Flags are only read on falling edges, after the level that set them has been registered.

// File: rtl/hlock_pkg.sv
package hlock_pkg;

   typedef enum logic [1:0] {
      SRC_INTERNAL = 2'd0,
      SRC_EXTERNAL = 2'd1,
      SRC_TEXT     = 2'd2
   } src_mode_e;

   // Integer fraction of a full-scale value, truncated.
   function automatic longint unsigned scale_level(input longint unsigned full,
                                                   input int unsigned num,
                                                   input int unsigned den);
      return (full * longint'(num)) / longint'(den);
   endfunction

endpackage

// File: rtl/hlock_rate_sel.sv
module hlock_rate_sel
   import hlock_pkg::*;
#(
   parameter int unsigned STEP_W      = 7,
   parameter int unsigned CHARGE_STEP = 125,
   parameter int unsigned LEAK_STEP   = 4,
   parameter int unsigned GATE_STEP   = 125
) (
   input  src_mode_e         mode_i,
   input  logic              sync_i,
   input  logic              gate_i,
   output logic [STEP_W-1:0] charge_o,
   output logic [STEP_W-1:0] dis_o
);

   localparam logic [STEP_W-1:0] CHG = STEP_W'(CHARGE_STEP);
   localparam logic [STEP_W-1:0] LKG = STEP_W'(LEAK_STEP);
   localparam logic [STEP_W-1:0] GTD = STEP_W'(GATE_STEP);

   initial begin
      assert (CHARGE_STEP < (2 ** STEP_W) && LEAK_STEP < (2 ** STEP_W)
              && GATE_STEP < (2 ** STEP_W))
         else $error("step values exceed STEP_W");
   end

   always_comb begin
      charge_o = '0;
      dis_o    = '0;
      unique case (mode_i)
         SRC_INTERNAL: begin
            // gated integration: sync wins, gate-only drains
            if (sync_i)      charge_o = CHG;
            else if (gate_i) dis_o    = GTD;
         end
         default: begin
            // continuous leak, gate window ignored
            if (sync_i) charge_o = CHG;
            dis_o = LKG;
         end
      endcase
   end

endmodule

// File: rtl/hlock_integrator.sv
module hlock_integrator #(
   parameter int unsigned ACC_W  = 16,
   parameter int unsigned STEP_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STEP_W-1:0] charge_i,
   input  logic [STEP_W-1:0] dis_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic [ACC_W-1:0]  acc_next_o
);

   localparam int unsigned SUM_W = ACC_W + 2;
   localparam logic [ACC_W-1:0] FULL = '1;

   initial begin
      assert (STEP_W <= ACC_W) else $error("STEP_W wider than ACC_W");
   end

   logic [ACC_W-1:0]        acc_q;
   logic signed [SUM_W-1:0] sum;

   always_comb begin
      sum = $signed(SUM_W'(acc_q)) + $signed(SUM_W'(charge_i))
          - $signed(SUM_W'(dis_i));
      if (sum < 0)
         acc_next_o = '0;
      else if (sum > $signed(SUM_W'(FULL)))
         acc_next_o = FULL;
      else
         acc_next_o = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_next_o;
   end

   assign acc_o = acc_q;

   assert_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (charge_i == '0 && dis_i == '0) |=> $stable(acc_q));

   assert_no_overflow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (charge_i >= dis_i) |=> (acc_q >= $past(acc_q)));

   assert_no_underflow_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (charge_i <= dis_i) |=> (acc_q <= $past(acc_q)));

endmodule

// File: rtl/hlock_hyst_cmp.sv
module hlock_hyst_cmp #(
   parameter int unsigned      W      = 16,
   parameter logic [W-1:0]     SET_TH = '1,
   parameter logic [W-1:0]     CLR_TH = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] val_i,
   output logic         flag_o
);

   initial begin
      assert (CLR_TH < SET_TH) else $error("hysteresis band inverted");
   end

   logic flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)               flag_q <= 1'b0;
      else if (val_i >= SET_TH) flag_q <= 1'b1;
      else if (val_i <  CLR_TH) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_band_hold_R6_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (val_i >= CLR_TH && val_i < SET_TH) |=> (flag_q == $past(flag_q)));

   assert_set_above_R6_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (val_i >= SET_TH) |=> flag_q);

   assert_clear_below_R6_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (val_i < CLR_TH) |=> !flag_q);

endmodule

// File: rtl/hlock_detector.sv
module hlock_detector
   import hlock_pkg::*;
#(
   parameter int unsigned ACC_W        = 16,
   parameter int unsigned CHARGE_STEP  = 125,
   parameter int unsigned LEAK_STEP    = 4,
   parameter int unsigned GATE_STEP    = 125,
   parameter int unsigned RATIO_DEN    = 98,
   parameter int unsigned SLOW_SET_NUM = 67,
   parameter int unsigned SLOW_CLR_NUM = 61,
   parameter int unsigned PRES_SET_NUM = 28,
   parameter int unsigned PRES_CLR_NUM = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_i,
   input  logic             gate_i,
   input  logic             ext_sel_i,
   input  logic             text_sel_i,
   output logic [ACC_W-1:0] level_o,
   output logic             in_sync_o,
   output logic             pd_slow_o,
   output logic             mute_o
);

   localparam int unsigned MAX_STEP =
      (CHARGE_STEP > LEAK_STEP)
         ? ((CHARGE_STEP > GATE_STEP) ? CHARGE_STEP : GATE_STEP)
         : ((LEAK_STEP > GATE_STEP) ? LEAK_STEP : GATE_STEP);
   localparam int unsigned STEP_W = $clog2(MAX_STEP + 1);
   localparam longint unsigned FULL_L = (64'd1 << ACC_W) - 64'd1;

   localparam logic [ACC_W-1:0] SLOW_SET =
      ACC_W'(scale_level(FULL_L, SLOW_SET_NUM, RATIO_DEN));
   localparam logic [ACC_W-1:0] SLOW_CLR =
      ACC_W'(scale_level(FULL_L, SLOW_CLR_NUM, RATIO_DEN));
   localparam logic [ACC_W-1:0] PRES_SET =
      ACC_W'(scale_level(FULL_L, PRES_SET_NUM, RATIO_DEN));
   localparam logic [ACC_W-1:0] PRES_CLR =
      ACC_W'(scale_level(FULL_L, PRES_CLR_NUM, RATIO_DEN));

   localparam int unsigned NCMP = 2;
   localparam logic [ACC_W-1:0] SET_TAB [NCMP] = '{SLOW_SET, PRES_SET};
   localparam logic [ACC_W-1:0] CLR_TAB [NCMP] = '{SLOW_CLR, PRES_CLR};
   localparam int unsigned IDX_SLOW = 0;
   localparam int unsigned IDX_PRES = 1;

   initial begin
      assert (ACC_W >= 4 && ACC_W <= 62) else $error("ACC_W out of range");
      assert (SLOW_SET_NUM <= RATIO_DEN && PRES_SET_NUM <= RATIO_DEN)
         else $error("threshold ratio above full scale");
      assert (CHARGE_STEP > LEAK_STEP) else $error("leak must be below charge");
   end

   src_mode_e        mode;
   logic             internal;
   logic [STEP_W-1:0] charge_amt;
   logic [STEP_W-1:0] dis_amt;
   logic [ACC_W-1:0] acc_now;
   logic [ACC_W-1:0] acc_nxt;
   logic [NCMP-1:0]  cmp_flag;

   always_comb begin
      if (text_sel_i)     mode = SRC_TEXT;
      else if (ext_sel_i) mode = SRC_EXTERNAL;
      else                mode = SRC_INTERNAL;
   end

   assign internal = (mode == SRC_INTERNAL);

   hlock_rate_sel #(
      .STEP_W      (STEP_W),
      .CHARGE_STEP (CHARGE_STEP),
      .LEAK_STEP   (LEAK_STEP),
      .GATE_STEP   (GATE_STEP)
   ) i_rate (
      .mode_i   (mode),
      .sync_i   (hsync_i),
      .gate_i   (gate_i),
      .charge_o (charge_amt),
      .dis_o    (dis_amt)
   );

   hlock_integrator #(
      .ACC_W  (ACC_W),
      .STEP_W (STEP_W)
   ) i_integ (
      .clk        (clk),
      .rst_n      (rst_n),
      .charge_i   (charge_amt),
      .dis_i      (dis_amt),
      .acc_o      (acc_now),
      .acc_next_o (acc_nxt)
   );

   // Comparators see the next level so flags move with the level.
   for (genvar c = 0; c < NCMP; c++) begin : g_cmp
      hlock_hyst_cmp #(
         .W      (ACC_W),
         .SET_TH (SET_TAB[c]),
         .CLR_TH (CLR_TAB[c])
      ) i_cmp (
         .clk    (clk),
         .rst_n  (rst_n),
         .val_i  (acc_nxt),
         .flag_o (cmp_flag[c])
      );
   end

   assign level_o   = acc_now;
   assign pd_slow_o = internal & cmp_flag[IDX_SLOW];
   assign mute_o    = ~cmp_flag[IDX_PRES];
   assign in_sync_o = internal & cmp_flag[IDX_PRES];

   assert_slow_level_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      pd_slow_o |-> (level_o >= SLOW_CLR));

   assert_mute_level_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      mute_o |-> (level_o < PRES_SET));

   assert_unmuted_level_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !mute_o |-> (level_o >= PRES_CLR));

   assert_lock_src_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      in_sync_o |-> (!ext_sel_i && !text_sel_i));

endmodule

// File: tb/test_hlock_detector.sv
module test_hlock_detector;

   typedef struct packed {
      logic        ext;
      logic        text;
      logic        sync;
      logic        gate;
      int unsigned n;
      logic [15:0] lvl;
      logic        slow;
      logic        mute;
      logic        ins;
      int unsigned req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b1,1'b0,   100, 16'd12500, 1'b0,1'b1,1'b0, 2},  // R2 charge, still muted
      '{1'b0,1'b0,1'b1,1'b0,   100, 16'd25000, 1'b0,1'b0,1'b1, 8},  // R8 presence on
      '{1'b0,1'b0,1'b1,1'b0,   160, 16'd45000, 1'b1,1'b0,1'b1, 6},  // R6 slow on
      '{1'b0,1'b0,1'b0,1'b1,    20, 16'd42500, 1'b1,1'b0,1'b1, 6},  // R6 hold in band, R3 gate drain
      '{1'b0,1'b0,1'b0,1'b1,    16, 16'd40500, 1'b0,1'b0,1'b1, 6},  // R6 slow off
      '{1'b0,1'b0,1'b0,1'b0,    50, 16'd40500, 1'b0,1'b0,1'b1, 3},  // R3 hold
      '{1'b0,1'b0,1'b1,1'b0,   300, 16'd65535, 1'b1,1'b0,1'b1, 5},  // R5 top clamp
      '{1'b1,1'b0,1'b0,1'b0,  1000, 16'd61535, 1'b0,1'b0,1'b0, 7},  // R7 forced fast, R4 leak
      '{1'b0,1'b0,1'b0,1'b0,     1, 16'd61535, 1'b1,1'b0,1'b1, 7},  // R7 state kept
      '{1'b1,1'b0,1'b1,1'b1,    10, 16'd62745, 1'b0,1'b0,1'b0, 4},  // R4 net charge, gate ignored
      '{1'b0,1'b1,1'b0,1'b0, 12000, 16'd14745, 1'b0,1'b0,1'b0, 8},  // R8 hold in band
      '{1'b0,1'b1,1'b0,1'b0,  3000, 16'd2745,  1'b0,1'b1,1'b0, 8},  // R8 mute on
      '{1'b0,1'b1,1'b0,1'b0,  1000, 16'd0,     1'b0,1'b1,1'b0, 5},  // R5 bottom clamp
      '{1'b0,1'b0,1'b0,1'b1,     5, 16'd0,     1'b0,1'b1,1'b0, 5},  // R5 no underflow
      '{1'b0,1'b0,1'b1,1'b0,   149, 16'd18625, 1'b0,1'b1,1'b0, 8},  // R8 one step below
      '{1'b0,1'b0,1'b1,1'b0,     1, 16'd18750, 1'b0,1'b0,1'b1, 10}  // R10 flag same edge
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync_i = 1'b0;
   logic        gate_i = 1'b0;
   logic        ext_sel_i = 1'b0;
   logic        text_sel_i = 1'b0;
   logic [15:0] level_o;
   logic        in_sync_o;
   logic        pd_slow_o;
   logic        mute_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   hlock_detector i_hlock_detector (
      .clk        (clk),
      .rst_n      (rst_n),
      .hsync_i    (hsync_i),
      .gate_i     (gate_i),
      .ext_sel_i  (ext_sel_i),
      .text_sel_i (text_sel_i),
      .level_o    (level_o),
      .in_sync_o  (in_sync_o),
      .pd_slow_o  (pd_slow_o),
      .mute_o     (mute_o)
   );

   task automatic check(input int unsigned req, input logic [15:0] lvl,
                        input logic slow, input logic mute, input logic ins);
      checks++;
      if (level_o !== lvl || pd_slow_o !== slow || mute_o !== mute
          || in_sync_o !== ins) begin
         errors++;
         $display("FAIL R%0d: level=%0d slow=%b mute=%b in_sync=%b expected level=%0d slow=%b mute=%b in_sync=%b",
                  req, level_o, pd_slow_o, mute_o, in_sync_o, lvl, slow, mute, ins);
      end
   endtask

   task automatic apply(input logic ext, input logic text, input logic sync,
                        input logic gate, input int unsigned n);
      ext_sel_i  = ext;
      text_sel_i = text;
      hsync_i    = sync;
      gate_i     = gate;
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(1, 16'd0, 1'b0, 1'b1, 1'b0);  // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check(1, 16'd0, 1'b0, 1'b1, 1'b0);  // R1 after release, idle
      for (int v = 0; v < NV; v++) begin
         apply(VEC[v].ext, VEC[v].text, VEC[v].sync, VEC[v].gate, VEC[v].n);
         check(VEC[v].req, VEC[v].lvl, VEC[v].slow, VEC[v].mute, VEC[v].ins);
      end
      // R9: presence held but source switched away from internal
      apply(1'b1, 1'b0, 1'b0, 1'b0, 1);
      check(9, 16'd18746, 1'b0, 1'b0, 1'b0);
      // R1: reset mid-run
      rst_n = 1'b0;
      apply(1'b0, 1'b0, 1'b1, 1'b0, 2);
      check(1, 16'd0, 1'b0, 1'b1, 1'b0);
      rst_n = 1'b1;
      // R2: sync and gate together, sync wins
      apply(1'b0, 1'b0, 1'b1, 1'b1, 4);
      check(2, 16'd500, 1'b0, 1'b1, 1'b0);
      // R4: text and external both set, leak only
      apply(1'b1, 1'b1, 1'b0, 1'b1, 1);
      check(4, 16'd496, 1'b0, 1'b1, 1'b0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule